// File: doc/BRIEF.md
# Run-Time Configurable PRBS Symbol Source with PAM4 Output

This block is a linear feedback shift register whose length (2 to 16 bits), feedback taps and starting value are chosen at run time. It is used to drive test patterns into a transmit path. Each enabled cycle it emits one symbol. In binary mode the symbol is one new bit. In PAM4 mode the symbol is two consecutive new bits, Gray-coded into a 2-bit level index.

Software or a test sequencer presents a width, a tap mask, a seed and a mode, then pulses `load`. From then on, each cycle with `enable` high advances the register and produces a symbol. If the register holds all zeros it can never leave that state, so the block raises a `stuck` flag for it.

Top module: `prbs_pam_gen`

## Requirements
- R1: After reset, `symOut` is 0, `symValid` is 0, and the state register is all zeros, so `stuck` is 1.
- R2: A cycle with `load` high copies `seed`, masked to the active width, into the state register. On the following cycle `symOut` is 0 and `symValid` is 0. `load` takes priority over `enable`, so no step happens in a load cycle.
- R3: In binary mode (`pam4Mode` = 0 at load), each step computes a new bit as the XOR of all bits of (tap mask AND state) inside the active width. The state shifts left by one, the new bit enters at bit 0, and bits at or above the width are cleared. `symOut` becomes {0, new bit}.
- R4: In PAM4 mode (`pam4Mode` = 1 at load), each enabled cycle performs two steps as in R3. The first bit becomes the MSB of a raw value and the second bit its LSB. The raw value is Gray-mapped 00→00, 01→01, 10→11, 11→10 onto `symOut`.
- R5: A cycle with both `enable` and `load` low leaves the state and `symOut` unchanged and gives `symValid` = 0 on the next cycle.
- R6: `symValid` is 1 exactly in the cycle after a cycle with `enable` high and `load` low.
- R7: The active width is `widthSel` clamped to the range 2 to 16. Values below 2 act as 2 and values above 16 act as 16. It is captured only at load.
- R8: `tapMask`, `seed`, `pam4Mode` and `widthSel` are sampled only in a load cycle. Changes at other times do not alter the symbol sequence.
- R9: `stuck` is 1 exactly when the state register is all zeros. While it is set, enabled cycles give `symOut` = 0 and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| load | input | 1 | Capture configuration and seed |
| enable | input | 1 | Advance and emit one symbol |
| pam4Mode | input | 1 | 1 = PAM4 Gray symbols, 0 = binary |
| widthSel | input | 5 | Requested register length |
| tapMask | input | 16 | Feedback tap mask |
| seed | input | 16 | Starting state |
| symOut | output | 2 | Current symbol |
| symValid | output | 1 | Symbol produced in the previous cycle |
| stuck | output | 1 | State register is all zeros |

## Verification
The properties assume that `load` and `enable` are clean synchronous levels and that the configuration inputs only matter in load cycles. For that reason no property looks at the taps, seed or mode outside a load. The stimulus changes every input half a cycle away from the rising edge. It also deliberately toggles the configuration buses between loads, so that the R8 checks can only pass if those values really are ignored.

// File: rtl/prbs_pam_pkg.sv
package prbs_pam_pkg;
  localparam int MAX_W  = 16;
  localparam int MIN_W  = 2;
  localparam int WSEL_W = 5;
  localparam int SYM_W  = 2;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;
    logic step;
  } prbsStrobe_t;
endpackage

// File: rtl/prbs_ctl.sv
module prbs_ctl
  import prbs_pam_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        load,
  input  logic        enable,
  output prbsStrobe_t strb,
  output logic        symValid
);
  always_comb begin
    strb.loadCfg = load;
    strb.step    = enable & ~load;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) symValid <= 1'b0;
    else       symValid <= strb.step;
  end
endmodule

// File: rtl/prbs_datapath.sv
module prbs_datapath
  import prbs_pam_pkg::*;
#(
  parameter int MAXW  = MAX_W,
  parameter int WSELW = WSEL_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  prbsStrobe_t      strb,
  input  logic             pam4Mode,
  input  logic [WSELW-1:0] widthSel,
  input  logic [MAXW-1:0]  tapMask,
  input  logic [MAXW-1:0]  seed,
  output logic [SYM_W-1:0] symOut,
  output logic             stuck
);
  localparam int STEPS = 2;

  logic [WSELW-1:0] cfgWidth;
  logic [MAXW-1:0]  cfgTaps;
  logic             cfgPam;
  logic [MAXW-1:0]  state;

  logic [WSELW-1:0] reqWidth;
  logic [MAXW-1:0]  loadMask;
  logic [MAXW-1:0]  actMask;

  // clamp requested width into supported range
  always_comb begin
    if (widthSel < WSELW'(MIN_W))      reqWidth = WSELW'(MIN_W);
    else if (widthSel > WSELW'(MAXW))  reqWidth = WSELW'(MAXW);
    else                               reqWidth = widthSel;
  end

  genvar gi;
  generate
    for (gi = 0; gi < MAXW; gi++) begin : g_mask
      assign loadMask[gi] = (WSELW'(gi) < reqWidth);
      assign actMask[gi]  = (WSELW'(gi) < cfgWidth);
    end
  endgenerate

  // chained shift stages, one bit each
  logic [STEPS:0][MAXW-1:0] stg;
  logic [STEPS-1:0]         newBit;
  assign stg[0] = state;

  generate
    for (gi = 0; gi < STEPS; gi++) begin : g_step
      assign newBit[gi]  = ^(stg[gi] & cfgTaps & actMask);
      assign stg[gi+1]   = ({stg[gi][MAXW-2:0], newBit[gi]}) & actMask;
    end
  endgenerate

  logic [MAXW-1:0]  nextState;
  logic [SYM_W-1:0] nextSym;
  logic [SYM_W-1:0] rawPair;

  always_comb begin
    rawPair = {newBit[0], newBit[1]};
    if (cfgPam) begin
      nextState = stg[2];
      nextSym   = {rawPair[1], rawPair[1] ^ rawPair[0]};
    end else begin
      nextState = stg[1];
      nextSym   = {1'b0, newBit[0]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgWidth <= WSELW'(MAXW);
      cfgTaps  <= '0;
      cfgPam   <= 1'b0;
      state    <= '0;
      symOut   <= '0;
    end else if (strb.loadCfg) begin
      cfgWidth <= reqWidth;
      cfgTaps  <= tapMask;
      cfgPam   <= pam4Mode;
      state    <= seed & loadMask;
      symOut   <= '0;
    end else if (strb.step) begin
      state    <= nextState;
      symOut   <= nextSym;
    end
  end

  assign stuck = (state == '0);
endmodule

// File: rtl/prbs_pam_gen.sv
module prbs_pam_gen
  import prbs_pam_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic              enable,
  input  logic              pam4Mode,
  input  logic [WSEL_W-1:0] widthSel,
  input  logic [MAX_W-1:0]  tapMask,
  input  logic [MAX_W-1:0]  seed,
  output logic [SYM_W-1:0]  symOut,
  output logic              symValid,
  output logic              stuck
);
  prbsStrobe_t strb;

  prbs_ctl u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .load     (load),
    .enable   (enable),
    .strb     (strb),
    .symValid (symValid)
  );

  prbs_datapath #(.MAXW(MAX_W), .WSELW(WSEL_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .pam4Mode (pam4Mode),
    .widthSel (widthSel),
    .tapMask  (tapMask),
    .seed     (seed),
    .symOut   (symOut),
    .stuck    (stuck)
  );
endmodule

// File: rtl/prbs_pam_gen_chk.sv
module prbs_pam_gen_chk (
  input logic       clk,
  input logic       rstN,
  input logic       load,
  input logic       enable,
  input logic [1:0] symOut,
  input logic       symValid,
  input logic       stuck
);
  // R2
  load_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    load |=> (symOut == 2'b00) && !symValid);

  // R5
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!load && !enable) |=> $stable(symOut) && !symValid);

  // R6
  step_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !load) |=> symValid);

  // R9
  zero_stays_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stuck && enable && !load) |=> stuck && (symOut == 2'b00));

  // R1
  always @(posedge clk) begin
    if (!rstN) begin
      reset_out_chk: assert (symOut == 2'b00 && !symValid);
    end
  end
endmodule

bind prbs_pam_gen prbs_pam_gen_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .load     (load),
  .enable   (enable),
  .symOut   (symOut),
  .symValid (symValid),
  .stuck    (stuck)
);

// File: tb/prbs_pam_gen_test.sv
`timescale 1ns/1ps
module prbs_pam_gen_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        load = 1'b0;
  logic        enable = 1'b0;
  logic        pam4Mode = 1'b0;
  logic [4:0]  widthSel = 5'd16;
  logic [15:0] tapMask = '0;
  logic [15:0] seed = '0;
  logic [1:0]  symOut;
  logic        symValid;
  logic        stuck;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  prbs_pam_gen uut (
    .clk(clk), .rstN(rstN), .load(load), .enable(enable),
    .pam4Mode(pam4Mode), .widthSel(widthSel), .tapMask(tapMask),
    .seed(seed), .symOut(symOut), .symValid(symValid), .stuck(stuck)
  );

  typedef struct packed {
    logic [4:0]  w;
    logic [15:0] taps;
    logic [15:0] sd;
    logic        pam;
    logic [7:0]  nSym;
    logic        hasFirst;
    logic [1:0]  firstSym;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{5'd13, 16'h1803, 16'h1AA0, 1'b1, 8'd40, 1'b0, 2'd0},
    '{5'd11, 16'h0630, 16'h03F5, 1'b0, 8'd60, 1'b0, 2'd0},
    '{5'd4,  16'h0009, 16'h0001, 1'b0, 8'd20, 1'b1, 2'd1},
    '{5'd4,  16'h0009, 16'h0001, 1'b1, 8'd10, 1'b1, 2'd2},
    '{5'd16, 16'hB400, 16'hACE1, 1'b0, 8'd50, 1'b0, 2'd0},
    '{5'd7,  16'h0060, 16'h0055, 1'b1, 8'd30, 1'b0, 2'd0}
  };

  // reference model state
  int          mW;
  logic [15:0] mTaps;
  logic [15:0] mState;
  logic        mPam;

  function automatic logic [15:0] wmask(int w);
    logic [15:0] m = '0;
    for (int i = 0; i < w; i++) m[i] = 1'b1;
    return m;
  endfunction

  task automatic mLoad(int wsel, logic [15:0] t, logic [15:0] s, logic p);
    mW = (wsel < 2) ? 2 : ((wsel > 16) ? 16 : wsel);
    mTaps = t;
    mPam = p;
    mState = s & wmask(mW);
  endtask

  task automatic mBit(output logic b);
    b = 1'b0;
    for (int i = 0; i < mW; i++) b = b ^ (mState[i] & mTaps[i]);
    mState = ((mState << 1) | {15'd0, b}) & wmask(mW);
  endtask

  task automatic mSym(output logic [1:0] sym);
    logic a, c;
    mBit(a);
    if (mPam) begin
      mBit(c);
      case ({a, c})
        2'b00: sym = 2'b00;
        2'b01: sym = 2'b01;
        2'b10: sym = 2'b11;
        default: sym = 2'b10;
      endcase
    end else begin
      sym = {1'b0, a};
    end
  endtask

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doLoad(int wsel, logic [15:0] t, logic [15:0] s, logic p);
    widthSel = 5'(wsel); tapMask = t; seed = s; pam4Mode = p;
    load = 1'b1; enable = 1'b0;
    cyc();
    load = 1'b0;
    mLoad(wsel, t, s, p);
  endtask

  // one enabled step, compare against model
  task automatic stepCheck(string req);
    logic [1:0] e;
    enable = 1'b1;
    cyc();
    enable = 1'b0;
    mSym(e);
    check(req, {30'd0, symOut}, {30'd0, e});
    check("R6", {31'd0, symValid}, 32'd1);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [1:0] held;
    logic [1:0] e;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {30'd0, symOut}, 32'd0);
    check("R1", {31'd0, symValid}, 32'd0);
    check("R9", {31'd0, stuck}, 32'd1);
    rstN = 1'b1;
    cyc();

    // R9: zero state stays zero
    enable = 1'b1;
    cyc(); cyc();
    enable = 1'b0;
    check("R9", {30'd0, symOut}, 32'd0);
    check("R9", {31'd0, stuck}, 32'd1);

    // table walk, R3 / R4
    for (int v = 0; v < NVEC; v++) begin
      doLoad(int'(VECS[v].w), VECS[v].taps, VECS[v].sd, VECS[v].pam);
      check("R2", {30'd0, symOut}, 32'd0);
      check("R2", {31'd0, symValid}, 32'd0);
      check("R9", {31'd0, stuck}, 32'd0);
      for (int k = 0; k < int'(VECS[v].nSym); k++) begin
        if (k == 0 && VECS[v].hasFirst) begin
          enable = 1'b1;
          cyc();
          enable = 1'b0;
          mSym(e);
          check(VECS[v].pam ? "R4" : "R3", {30'd0, symOut}, {30'd0, VECS[v].firstSym});
        end else begin
          stepCheck(VECS[v].pam ? "R4" : "R3");
        end
      end
    end

    // R3 hand: w4 taps 9 seed 1 gives 1,1,1,0; upper seed bits masked
    doLoad(4, 16'h0009, 16'hFFF1, 1'b0);
    enable = 1'b1;
    cyc(); check("R3", {30'd0, symOut}, 32'd1);
    cyc(); check("R3", {30'd0, symOut}, 32'd1);
    cyc(); check("R3", {30'd0, symOut}, 32'd1);
    cyc(); check("R3", {30'd0, symOut}, 32'd0);
    enable = 1'b0;

    // R4 hand: second PAM4 symbol of same config is raw 10 -> 11
    doLoad(4, 16'h0009, 16'h0001, 1'b1);
    enable = 1'b1;
    cyc(); check("R4", {30'd0, symOut}, 32'd2);
    cyc(); check("R4", {30'd0, symOut}, 32'd3);
    enable = 1'b0;

    // R2: load wins over enable
    widthSel = 5'd11; tapMask = 16'h0630; seed = 16'h03F5; pam4Mode = 1'b0;
    load = 1'b1; enable = 1'b1;
    cyc();
    load = 1'b0; enable = 1'b0;
    mLoad(11, 16'h0630, 16'h03F5, 1'b0);
    check("R2", {30'd0, symOut}, 32'd0);
    check("R2", {31'd0, symValid}, 32'd0);
    for (int k = 0; k < 5; k++) stepCheck("R2");

    // R5: idle cycles hold
    held = symOut;
    for (int k = 0; k < 3; k++) begin
      cyc();
      check("R5", {30'd0, symOut}, {30'd0, held});
      check("R5", {31'd0, symValid}, 32'd0);
    end
    for (int k = 0; k < 5; k++) stepCheck("R5");

    // R8: config changes without load are ignored
    tapMask = 16'hFFFF; seed = 16'h1234; pam4Mode = 1'b1; widthSel = 5'd3;
    for (int k = 0; k < 20; k++) stepCheck("R8");

    // R7: clamp low and high
    doLoad(0, 16'h0003, 16'hFFFF, 1'b0);
    for (int k = 0; k < 8; k++) stepCheck("R7");
    doLoad(31, 16'hB400, 16'hFFFF, 1'b1);
    for (int k = 0; k < 20; k++) stepCheck("R7");

    // R9: seed with only bits above width -> stuck
    doLoad(4, 16'h0009, 16'h0100, 1'b0);
    check("R9", {31'd0, stuck}, 32'd1);
    enable = 1'b1; cyc(); enable = 1'b0;
    check("R9", {30'd0, symOut}, 32'd0);
    check("R9", {31'd0, stuck}, 32'd1);

    finishRun();
  end
endmodule